// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block connects a simple processor bus to a raw 8-bit NAND flash device through a small memory-mapped window. Byte reads and writes anywhere in the low 2 KB of the window turn into flash data cycles, so a block transfer can use incrementing addresses. A set of even-offset aliases holds a control register. That register drives the chip-enable, command-latch and address-latch pins and the two interrupt enables. A set of odd-offset aliases sends one command or address byte to the flash, using whatever latch pins the control register holds at that moment. A status byte reports the flash ready pin, the controller busy flag, a sticky cycle-complete flag and a sticky distract flag.

The bus side is a request/ready handshake. The master holds `bus_req` and its address, direction and write data until `bus_ready` pulses for one cycle. Flash writes are posted: the bus acknowledges them at once, and the flash cycle then runs in the background. Status reads are always answered at once. Any access that needs the flash pins or the control register waits while a cycle is still running. That access is held off, not dropped.

The bus state machine has three states. B_IDLE accepts a request. It moves to B_RESP for register accesses and posted writes, and to B_RDWAIT for data reads. It stays in B_IDLE while the access must wait. B_RDWAIT moves to B_RESP when the flash cycle ends. B_RESP returns to B_IDLE. The pin sequencer also has three states. Q_IDLE moves to Q_STROBE on a start. Q_STROBE moves to Q_HOLD after STROBE_CLKS cycles. Q_HOLD moves back to Q_IDLE after HOLD_CLKS cycles.

Top module: `nand_host_bridge`

## Requirements
- R1: Offset decode. Offsets 0x000–0x7FF are the data port. Even offsets 0x800–0x80E are the control register. Odd offsets 0x801–0x80F are the command/address port on write. Offset 0x810 is status. Writes to any other offset are ignored. Reads of any other offset, and reads of an odd alias, return 0x00 and start no flash cycle.
- R2: Control register fields:
  - bit0 drives `nf_ce_n` directly, so 0 enables the chip;
  - bit1 drives `nf_cle`;
  - bit2 drives `nf_ale`;
  - bit3 enables the ready-rise interrupt;
  - bit4 enables the distract interrupt.
  Reads return the five bits with bits 7:5 as zero.
- R3: A flash write drives `nf_we_n` low for exactly STROBE_CLKS cycles (default 4). `nf_dq_oe` stays high and `nf_dq_out` stays unchanged for HOLD_CLKS cycles (default 1) after `nf_we_n` rises.
- R4: A data-window read drives `nf_re_n` low for STROBE_CLKS cycles. It returns on `bus_rdata` the byte present on `nf_dq_in` in the cycle in which `nf_re_n` rises.
- R5: A command/address byte and a data write both go out under the CLE/ALE levels held in the control register.
- R6: Status byte layout:
  - bit3 is the synchronised `nf_rb` level (1 means the flash is ready);
  - bit2 is controller busy;
  - bit1 is cycle complete;
  - bit0 is distract;
  - bits 7:4 are zero.
- R7: Flash writes are acknowledged before their cycle ends. Busy reads 1 from the start of a cycle to its end. Status reads never wait.
- R8: A data access, a command write or a control write that arrives while a cycle runs waits until the sequencer is idle. It is then performed in order and is never lost. The control pins do not change during a cycle.
- R9: Cycle complete is set when a flash cycle finishes and cleared by a status read. A finishing cycle wins over a clearing read in the same cycle.
- R10: Distract is set when the synchronised `nf_rb` falls while control bit0 is 1. It is not set when bit0 is 0. A status read clears it.
- R11: `irq` is high when (the ready-rise flag is set and bit3 is 1) or (distract is set and bit4 is 1). The ready-rise flag sets on a rising synchronised `nf_rb`, and a status read clears it.
- R12: A control write with bit0 = 1 clears the cycle-complete, distract and ready-rise flags.
- R13: After reset, the outputs are as follows:
  - `nf_ce_n` = 1, and the control register reads 0x01;
  - `nf_cle`, `nf_ale`, `nf_dq_oe`, `irq` and `bus_ready` are 0;
  - `nf_we_n` and `nf_re_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset inside the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | One-cycle completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Data driven to the flash |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_out` |
| nf_dq_in | input | 8 | Data from the flash |
| nf_rb | input | 1 | Flash ready (high) / busy (low) pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a control write that arrives while a posted command byte is still strobing. If the bridge let that write through, the byte already on the bus would rise under the wrong latch pins. Nothing on the bus side would show this; only the recorded pin levels reveal it. The stimulus issues two address bytes back to back and follows them at once with a control write that switches from ALE to CLE. The behavioural responder records the CLE/ALE level, strobe width and data hold at every write-strobe rising edge. Those records are compared with the expected sequence. Random data, command and read traffic then repeats the pattern with varied offsets and latch settings.

// File: rtl/nhb_pkg.sv
package nhb_pkg;

    typedef enum logic [2:0] {
        ACC_DATA,
        ACC_CTRL,
        ACC_CMD,
        ACC_STAT,
        ACC_NONE
    } acc_kind_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_RDWAIT,
        B_RESP
    } bus_state_t;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_STROBE,
        Q_HOLD
    } seq_state_t;

    // control register field positions (software depends on these)
    localparam int CTL_CE_OFF  = 0;
    localparam int CTL_CLE     = 1;
    localparam int CTL_ALE     = 2;
    localparam int CTL_RDY_IE  = 3;
    localparam int CTL_DIST_IE = 4;
    localparam int CTL_W       = 5;

    // status byte field positions
    localparam int ST_DIST = 0;
    localparam int ST_CMP  = 1;
    localparam int ST_BUSY = 2;
    localparam int ST_RDY  = 3;

endpackage

// File: rtl/nhb_decode.sv
module nhb_decode
    import nhb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_SPAN  = 2048,
    parameter int ALIAS_SPAN = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind
);
    localparam int STAT_OFF = DATA_SPAN + ALIAS_SPAN;

    always_comb begin
        if (int'(addr) < DATA_SPAN) begin
            kind = ACC_DATA;
        end else if (int'(addr) < STAT_OFF) begin
            kind = addr[0] ? ACC_CMD : ACC_CTRL;
        end else if (int'(addr) == STAT_OFF) begin
            kind = ACC_STAT;
        end else begin
            kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/nhb_strobe_seq.sv
module nhb_strobe_seq
    import nhb_pkg::*;
#(
    parameter int STROBE_CLKS = 4,
    parameter int HOLD_CLKS   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_rd,
    input  logic [7:0] wdata,
    input  logic [7:0] dq_in,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_byte
);
    localparam int MAX_CLKS = (STROBE_CLKS > HOLD_CLKS) ? STROBE_CLKS : HOLD_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_CLKS - 1);
    localparam logic [CNT_W-1:0] HLD_LAST = CNT_W'(HOLD_CLKS - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rd_q;
    logic [7:0]       dq_q;
    logic [7:0]       rd_byte_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            Q_IDLE: begin
                if (start) begin
                    state_d = Q_STROBE;
                    cnt_d   = '0;
                end
            end
            Q_STROBE: begin
                if (cnt_q == STB_LAST) begin
                    state_d = Q_HOLD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            Q_HOLD: begin
                if (cnt_q == HLD_LAST) begin
                    state_d = Q_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = Q_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // operand capture and read sampling on the strobe's rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            dq_q      <= '0;
            rd_byte_q <= '0;
        end else begin
            if (state_q == Q_IDLE && start) begin
                rd_q <= start_rd;
                dq_q <= wdata;
            end
            if (state_q == Q_STROBE && cnt_q == STB_LAST && rd_q) begin
                rd_byte_q <= dq_in;
            end
        end
    end

    // outputs
    always_comb begin
        we_n    = !(state_q == Q_STROBE && !rd_q);
        re_n    = !(state_q == Q_STROBE && rd_q);
        dq_oe   = (state_q != Q_IDLE) && !rd_q;
        dq_out  = dq_q;
        busy    = (state_q != Q_IDLE);
        done    = (state_q == Q_HOLD) && (cnt_q == HLD_LAST);
        rd_byte = rd_byte_q;
    end

    // the bus side only launches a cycle into an idle sequencer
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state_q == Q_IDLE);

    // written data does not move while held after the strobe
    p_dq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_HOLD && !rd_q) |-> (dq_oe && $stable(dq_q)));

    // read strobe and write strobe never overlap
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

endmodule

// File: rtl/nhb_status.sv
module nhb_status
    import nhb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rb_pin,
    input  logic       ce_off,
    input  logic       rdy_ie,
    input  logic       dist_ie,
    input  logic       seq_busy,
    input  logic       seq_done,
    input  logic       stat_rd,
    input  logic       flag_clr,
    output logic [7:0] status,
    output logic       irq
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rb_prev_q;
    logic                   rb_now;
    logic                   rb_rise;
    logic                   rb_fall;
    logic                   cmp_q;
    logic                   dist_q;
    logic                   rise_q;

    // ready/busy pin synchroniser, reset to "ready"
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '1;
            rb_prev_q <= 1'b1;
        end else begin
            sync_q    <= {sync_q[SYNC_STAGES-2:0], rb_pin};
            rb_prev_q <= rb_now;
        end
    end

    always_comb begin
        rb_now  = sync_q[SYNC_STAGES-1];
        rb_rise = rb_now && !rb_prev_q;
        rb_fall = !rb_now && rb_prev_q;
    end

    // sticky event flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= 1'b0;
            dist_q <= 1'b0;
            rise_q <= 1'b0;
        end else if (flag_clr) begin
            cmp_q  <= 1'b0;
            dist_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            cmp_q  <= seq_done || (cmp_q && !stat_rd);
            dist_q <= (rb_fall && ce_off) || (dist_q && !stat_rd);
            rise_q <= rb_rise || (rise_q && !stat_rd);
        end
    end

    always_comb begin
        status          = '0;
        status[ST_RDY]  = rb_now;
        status[ST_BUSY] = seq_busy;
        status[ST_CMP]  = cmp_q;
        status[ST_DIST] = dist_q;
        irq             = (rise_q && rdy_ie) || (dist_q && dist_ie);
    end

    p_cmp_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> status[ST_CMP]);

    p_dist_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_DIST]) |-> $past(ce_off));

    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdy_ie || dist_ie));

    p_flag_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!status[ST_CMP] && !status[ST_DIST]));

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
    import nhb_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_SPAN   = 2048,
    parameter int ALIAS_SPAN  = 16,
    parameter int STROBE_CLKS = 4,
    parameter int HOLD_CLKS   = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_ready,
    output logic              nf_ce_n,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_dq_out,
    output logic              nf_dq_oe,
    input  logic [7:0]        nf_dq_in,
    input  logic              nf_rb,
    output logic              irq
);
    localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1);

    bus_state_t       bstate_q, bstate_d;
    acc_kind_t        kind;
    logic [CTL_W-1:0] ctrl_q;
    logic [7:0]       rdata_q, rdata_d;
    logic             need_flash;
    logic             need_quiet;
    logic             seq_start;
    logic             seq_start_rd;
    logic             seq_busy;
    logic             seq_done;
    logic [7:0]       seq_rd_byte;
    logic             ctrl_we;
    logic             stat_rd;
    logic             flag_clr;
    logic [7:0]       status;

    nhb_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_SPAN  (DATA_SPAN),
        .ALIAS_SPAN (ALIAS_SPAN)
    ) u_decode (
        .addr (bus_addr),
        .kind (kind)
    );

    nhb_strobe_seq #(
        .STROBE_CLKS (STROBE_CLKS),
        .HOLD_CLKS   (HOLD_CLKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .start_rd (seq_start_rd),
        .wdata    (bus_wdata),
        .dq_in    (nf_dq_in),
        .we_n     (nf_we_n),
        .re_n     (nf_re_n),
        .dq_out   (nf_dq_out),
        .dq_oe    (nf_dq_oe),
        .busy     (seq_busy),
        .done     (seq_done),
        .rd_byte  (seq_rd_byte)
    );

    nhb_status #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_pin   (nf_rb),
        .ce_off   (ctrl_q[CTL_CE_OFF]),
        .rdy_ie   (ctrl_q[CTL_RDY_IE]),
        .dist_ie  (ctrl_q[CTL_DIST_IE]),
        .seq_busy (seq_busy),
        .seq_done (seq_done),
        .stat_rd  (stat_rd),
        .flag_clr (flag_clr),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        need_flash = (kind == ACC_DATA) || (kind == ACC_CMD && bus_we);
        need_quiet = need_flash || (kind == ACC_CTRL && bus_we);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bstate_q <= B_IDLE;
            rdata_q  <= '0;
        end else begin
            bstate_q <= bstate_d;
            rdata_q  <= rdata_d;
        end
    end

    // next state and per-access actions
    always_comb begin
        bstate_d     = bstate_q;
        rdata_d      = rdata_q;
        seq_start    = 1'b0;
        seq_start_rd = 1'b0;
        ctrl_we      = 1'b0;
        stat_rd      = 1'b0;
        unique case (bstate_q)
            B_IDLE: begin
                if (bus_req && !(need_quiet && seq_busy)) begin
                    bstate_d = B_RESP;
                    rdata_d  = '0;
                    if (kind == ACC_STAT && !bus_we) begin
                        stat_rd = 1'b1;
                        rdata_d = status;
                    end else if (kind == ACC_CTRL) begin
                        if (bus_we) begin
                            ctrl_we = 1'b1;
                        end else begin
                            rdata_d = 8'(ctrl_q);
                        end
                    end else if (need_flash) begin
                        seq_start    = 1'b1;
                        seq_start_rd = !bus_we;
                        if (!bus_we) begin
                            bstate_d = B_RDWAIT;
                        end
                    end
                end
            end
            B_RDWAIT: begin
                if (seq_done) begin
                    bstate_d = B_RESP;
                    rdata_d  = seq_rd_byte;
                end
            end
            B_RESP: begin
                bstate_d = B_IDLE;
            end
            default: begin
                bstate_d = B_IDLE;
            end
        endcase
    end

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTL_RESET;
        end else if (ctrl_we) begin
            ctrl_q <= bus_wdata[CTL_W-1:0];
        end
    end

    // outputs
    always_comb begin
        bus_ready = (bstate_q == B_RESP);
        bus_rdata = rdata_q;
        nf_ce_n   = ctrl_q[CTL_CE_OFF];
        nf_cle    = ctrl_q[CTL_CLE];
        nf_ale    = ctrl_q[CTL_ALE];
        flag_clr  = ctrl_we && bus_wdata[CTL_CE_OFF];
    end

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_stat_nostall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bstate_q == B_IDLE && bus_req && kind == ACC_STAT) |=> bus_ready);

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bstate_q == B_IDLE && bus_req && need_quiet && seq_busy) |=> !bus_ready);

    p_ctl_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> $stable(ctrl_q));

endmodule

// File: tb/tb_nand_host_bridge.sv
`timescale 1ns/1ps
module tb_nand_host_bridge;
    localparam int STB = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        bus_ready;
    logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_rb, irq;
    logic [7:0]  nf_dq_out, nf_dq_in;

    always #2 clk = ~clk;

    nand_host_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int n);
        return 8'(n * 37 + 90);
    endfunction

    // behavioural flash responder
    logic [7:0] rec_byte [0:255];
    logic       rec_cle  [0:255];
    logic       rec_ale  [0:255];
    int         rec_w    [0:255];
    logic       rec_hold [0:255];
    int rec_n = 0, we_low = 0, re_low = 0, rd_n = 0, re_w_last = 0, widx = 0;

    assign nf_dq_in = pat(rd_n);

    always @(posedge clk) begin
        if (rst_n === 1'b1 && nf_we_n === 1'b0) we_low++;
        if (rst_n === 1'b1 && nf_re_n === 1'b0) re_low++;
    end

    always @(posedge nf_we_n) begin
        if (rst_n === 1'b1) begin
            widx = rec_n;
            rec_byte[widx] = nf_dq_out;
            rec_cle[widx]  = nf_cle;
            rec_ale[widx]  = nf_ale;
            rec_w[widx]    = we_low;
            we_low = 0;
            rec_n++;
            @(negedge clk);
            rec_hold[widx] = nf_dq_oe && (nf_dq_out == rec_byte[widx]);
        end
    end

    always @(posedge nf_re_n) begin
        if (rst_n === 1'b1) begin
            re_w_last = re_low;
            re_low = 0;
            rd_n++;
        end
    end

    // expected model
    logic [7:0] exp_byte [0:255];
    logic       exp_cle  [0:255];
    logic       exp_ale  [0:255];
    int exp_n = 0, exp_rd = 0;
    logic [7:0] ctl_m = 8'h01;

    task automatic bus_xfer(input logic we, input logic [11:0] addr,
                            input logic [7:0] wd, output logic [7:0] rd);
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        do @(negedge clk); while (bus_ready !== 1'b1);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic wr(input logic [11:0] addr, input logic [7:0] d);
        logic [7:0] dummy;
        bus_xfer(1'b1, addr, d, dummy);
    endtask

    task automatic rd(input logic [11:0] addr, output logic [7:0] d);
        bus_xfer(1'b0, addr, 8'h00, d);
    endtask

    task automatic flash_wr(input logic [11:0] addr, input logic [7:0] d);
        exp_byte[exp_n] = d;
        exp_cle[exp_n]  = ctl_m[1];
        exp_ale[exp_n]  = ctl_m[2];
        exp_n++;
        wr(addr, d);
    endtask

    task automatic ctl_wr(input logic [11:0] addr, input logic [7:0] d);
        ctl_m = {3'b000, d[4:0]};
        wr(addr, d);
    endtask

    task automatic wait_idle(output logic [7:0] s);
        s = 8'h04;
        for (int i = 0; i < 64 && s[2]; i++) rd(12'h810, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        int snap;
        void'($urandom(32'd20240611));
        bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; nf_rb = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 ce_n", nf_ce_n, 1);
        check("R13 cle/ale", {nf_cle, nf_ale}, 0);
        check("R13 strobes", {nf_we_n, nf_re_n}, 2'b11);
        check("R13 oe/irq/ready", {nf_dq_oe, irq, bus_ready}, 0);
        rd(12'h800, d); check("R13 ctrl reset value", d, 8'h01);
        rd(12'h810, s); check("R6 status after reset", s, 8'h08);

        // R2 control fields and R1 even alias
        ctl_wr(12'h806, 8'h02);
        check("R2 ce_n follows bit0", nf_ce_n, 0);
        check("R2 cle/ale pins", {nf_cle, nf_ale}, 2'b10);
        rd(12'h80C, d); check("R1 even alias reads control", d, 8'h02);
        wr(12'h800, 8'hFC); ctl_m = 8'h1C;
        rd(12'h802, d); check("R2 upper bits read zero", d, 8'h1C);
        check("R2 ale pin", {nf_cle, nf_ale}, 2'b01);
        ctl_wr(12'h800, 8'h02);

        // R7/R9 posted command byte, busy visible, complete flag
        flash_wr(12'h80B, 8'h90);
        rd(12'h810, s); check("R7 busy during cycle", s[2], 1);
        wait_idle(s);
        check("R9 complete after cycle", s[1], 1);
        check("R6 upper nibble zero", s[7:4], 0);
        rd(12'h810, s); check("R9 complete cleared by read", s[1], 0);

        // R8 back-to-back address bytes and a control write that must wait
        ctl_wr(12'h800, 8'h04);
        flash_wr(12'h801, 8'h11);
        flash_wr(12'h80F, 8'h22);
        ctl_wr(12'h808, 8'h02);
        check("R8 control applied after wait", {nf_cle, nf_ale}, 2'b10);
        flash_wr(12'h803, 8'h33);

        // R4 data reads at both ends of the window
        rd(12'h7FF, d); check("R4 read at top of window", d, pat(exp_rd)); exp_rd++;
        check("R4 read strobe width", re_w_last, STB);
        rd(12'h000, d); check("R4 read at offset 0", d, pat(exp_rd)); exp_rd++;

        // R1 ignored offsets
        wait_idle(s);
        snap = rec_n;
        wr(12'h811, 8'hFF);
        wr(12'hA00, 8'hFF);
        rd(12'h811, d); check("R1 unmapped read zero", d, 0);
        rd(12'h805, d); check("R1 odd alias read zero", d, 0);
        repeat (10) @(negedge clk);
        check("R1 no cycle from ignored access", rec_n, snap);
        rd(12'h800, d); check("R1 control unchanged", d, 8'h02);
        check("R1 no read cycle", rd_n, exp_rd);

        // random traffic
        for (int it = 0; it < 30; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                flash_wr(12'($urandom % 2048), 8'($urandom));
            end else if (op == 1) begin
                ctl_wr(12'h800 + 12'(2 * ($urandom % 8)), 8'(($urandom % 4) << 1));
                flash_wr(12'h801 + 12'(2 * ($urandom % 8)), 8'($urandom));
            end else begin
                rd(12'($urandom % 2048), d);
                check("R4 random read data", d, pat(exp_rd));
                exp_rd++;
            end
        end
        wait_idle(s);
        repeat (4) @(negedge clk);

        // write cycle records vs expectations (R3, R5, R8)
        check("R8 every write reached flash", rec_n, exp_n);
        for (int k = 0; k < exp_n && k < rec_n; k++) begin
            check("R3 written byte", rec_byte[k], exp_byte[k]);
            check("R5 cle/ale at strobe", {rec_cle[k], rec_ale[k]}, {exp_cle[k], exp_ale[k]});
            check("R3 write strobe width", rec_w[k], STB);
            check("R3 data held after strobe", rec_hold[k], 1);
        end

        // R10/R11 distract with chip disabled
        ctl_wr(12'h800, 8'h11);
        check("R11 irq low after clear", irq, 0);
        nf_rb = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 distract irq", irq, 1);
        rd(12'h810, s);
        check("R10 distract flag", s[0], 1);
        check("R6 ready bit low", s[3], 0);
        check("R10 distract cleared by read", irq, 0);
        nf_rb = 1'b1;
        repeat (6) @(negedge clk);
        check("R11 ready rise masked", irq, 0);
        rd(12'h810, s);

        // R10/R11 ready rise with chip enabled
        ctl_wr(12'h800, 8'h08);
        nf_rb = 1'b0;
        repeat (6) @(negedge clk);
        rd(12'h810, s);
        check("R10 no distract while enabled", s[0], 0);
        check("R11 no irq while busy", irq, 0);
        nf_rb = 1'b1;
        repeat (6) @(negedge clk);
        check("R11 ready rise irq", irq, 1);
        rd(12'h810, s);
        check("R11 irq cleared by status read", irq, 0);

        // R12 reset bit clears pending complete
        ctl_wr(12'h800, 8'h00);
        flash_wr(12'h805, 8'h70);
        repeat (12) @(negedge clk);
        ctl_wr(12'h800, 8'h01);
        rd(12'h810, s);
        check("R12 complete cleared by reset bit", s[1], 0);
        check("R12 chip deselected", nf_ce_n, 1);
        check("R5 last byte under cle=0", {rec_byte[rec_n-1], rec_cle[rec_n-1]}, {8'h70, 1'b0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule